// File: doc/BRIEF.md
# Transmit Descriptor-Ring Gather Engine

This block drains a ring of transmit descriptors that software has placed in host memory. Each eight-byte slot gives the address of a data fragment, its byte count minus one, and a flags half-word. After a kick write to the control register the engine reads slots in order. It copies each valid slot's fragment into a local frame buffer at a running offset, and rewrites the slot with its valid and status flags cleared. When it reaches a slot that carries the last flag, it plays the assembled frame out on a byte stream and raises the frame-sent interrupt status bit.

A walk ends on the first slot whose valid flag is clear, after a last-flag slot, or once the programmed ring size has been visited, whichever comes first. The slot index and the buffer offset persist between kicks, so a frame may be built across several kicks. A control bit rewinds both to zero. Host memory is reached through a single request/ready port carrying 32-bit words. A fragment byte is taken from the low byte of the returned word.

Top module: `tx_gather_engine`

## Requirements
- R1: Slot i lives at ring base + 8*i, and the low three bits of the written base are ignored. The word at +0 is the fragment address. The word at +4 holds the stored length in bits 15:0 and the flags in bits 31:16.
- R2: For a valid slot, stored length + 1 bytes are read from consecutive addresses starting at the fragment address and appended to the frame buffer at the running offset. The offset is kept across slots and across kicks until a frame is sent.
- R3: A frame goes out only when a valid slot with the last flag (flags bit 0) has been gathered. It is the concatenation of all fragments since the previous frame, one byte per cycle, with the final byte marked.
- R4: A walk stops at the first slot whose valid flag (flags bit 15) is clear. That slot is neither consumed nor rewritten, and the next kick starts from it.
- R5: One kick visits at most ring-size slots. The slot index wraps to zero when it reaches the ring size, and a ring size of zero makes a kick do nothing.
- R6: Every consumed slot has its +4 word rewritten with the length unchanged and flags bits 15:1 cleared, keeping only the last flag. The slot is rewritten after its frame, if any, has been sent.
- R7: Sending a frame sets interrupt status bit 4 and leaves the other bits as they are. Writing ones to the clear register clears those status bits. The interrupt is high exactly when mask AND status is nonzero.
- R8: The idle output is high after reset. It drops in the cycle after a kick is accepted and rises again when the walk ends.
- R9: Control bit 1 rewinds the slot index and the frame-buffer offset to zero. When it is written together with a kick, the rewind takes effect first.
- R10: A fragment that would take the frame past MTU + 128 bytes is not copied. It sets interrupt status bit 5, its slot is still rewritten, and the bytes gathered before it are kept.
- R11: A memory request holds its address, direction and data until the cycle in which ready is seen.
- R12: Writes to the control, base and size registers are ignored while the engine is not idle.
- R13: After reset: idle is high, there is no memory request and no stream byte, and the interrupt status and output are zero.

Register map (reg_addr): 0 control (bit 0 kick, bit 1 rewind), 1 ring base, 2 ring size, 3 interrupt mask, 4 write-one-to-clear interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| idle | output | 1 | No walk in progress |
| irq_status | output | 8 | Interrupt status bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with an MTU of 4, so the frame buffer holds only 132 bytes. It uses a 4-bit ring index and programs a ring size of 4. With these values, overflow is reached with just two fragments, and every kick crosses the wrap point within a handful of slots. A sweep then covers one to three fragments per frame, with lengths and junk status flags taken from a formula and each frame starting at a different slot. Further cases cover a walk halted by an invalid slot, a full-ring walk without a last flag, a rewind combined with a kick, overflow, and register writes made mid-walk.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;

    // Descriptor flag positions (bits of the upper half of the +4 word)
    localparam int unsigned FLAG_VALID_BIT = 15;
    localparam int unsigned FLAG_LAST_BIT  = 0;
    localparam logic [15:0] FLAG_KEEP_MASK = 16'h0001;

    // Interrupt status positions
    localparam int unsigned STAT_SENT_BIT = 4;
    localparam int unsigned STAT_DROP_BIT = 5;

    // Register select codes
    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_BASE  = 3'd1;
    localparam logic [2:0] REG_SIZE  = 3'd2;
    localparam logic [2:0] REG_MASK  = 3'd3;
    localparam logic [2:0] REG_CLEAR = 3'd4;

    // Control bits
    localparam int unsigned CTRL_KICK_BIT   = 0;
    localparam int unsigned CTRL_REWIND_BIT = 1;

    typedef enum logic [2:0] {
        W_IDLE  = 3'd0,
        W_DADDR = 3'd1,
        W_DCTL  = 3'd2,
        W_FRAG  = 3'd3,
        W_EMIT  = 3'd4,
        W_WBACK = 3'd5
    } walk_state_e;

endpackage

// File: rtl/tx_gather_cfg.sv
module tx_gather_cfg
    import tx_gather_pkg::*;
#(
    parameter int unsigned RING_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic              busy_i,
    output logic [31:0]       ring_base_o,
    output logic [RING_W-1:0] ring_size_o,
    output logic              start_o,
    output logic              rewind_o
);

    typedef struct packed {
        logic [31:0]       base;
        logic [RING_W-1:0] size;
    } cfg_t;

    cfg_t d, q;

    always_comb begin
        d        = q;
        start_o  = 1'b0;
        rewind_o = 1'b0;
        if (reg_we_i && !busy_i) begin
            case (reg_addr_i)
                REG_CTRL: begin
                    start_o  = reg_wdata_i[CTRL_KICK_BIT];
                    rewind_o = reg_wdata_i[CTRL_REWIND_BIT];
                end
                REG_BASE: d.base = {reg_wdata_i[31:3], 3'b000};
                REG_SIZE: d.size = reg_wdata_i[RING_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ring_base_o = q.base;
    assign ring_size_o = q.size;

endmodule

// File: rtl/tx_gather_irq.sv
module tx_gather_irq
    import tx_gather_pkg::*;
#(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic              sent_i,
    input  logic              drop_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] status;
    } irq_t;

    irq_t d, q;

    always_comb begin
        d = q;
        if (reg_we_i && reg_addr_i == REG_MASK)
            d.mask = reg_wdata_i[STAT_W-1:0];
        if (reg_we_i && reg_addr_i == REG_CLEAR)
            d.status = q.status & ~reg_wdata_i[STAT_W-1:0];
        // a new event wins over a clear in the same cycle
        if (sent_i) d.status[STAT_SENT_BIT] = 1'b1;
        if (drop_i) d.status[STAT_DROP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status_o = q.status;
    assign irq_o    = |(q.mask & q.status);

endmodule

// File: rtl/tx_gather_fbuf.sv
module tx_gather_fbuf #(
    parameter int unsigned DEPTH = 1628,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/tx_gather_walker.sv
module tx_gather_walker
    import tx_gather_pkg::*;
#(
    parameter int unsigned RING_W    = 8,
    parameter int unsigned BUF_BYTES = 1628,
    localparam int unsigned BUF_AW   = $clog2(BUF_BYTES),
    localparam int unsigned OFF_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rewind_i,
    input  logic [31:0]       ring_base_i,
    input  logic [RING_W-1:0] ring_size_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              buf_we_o,
    output logic [BUF_AW-1:0] buf_waddr_o,
    output logic [7:0]        buf_wdata_o,
    output logic [BUF_AW-1:0] buf_raddr_o,
    output logic              tx_valid_o,
    output logic              tx_last_o,
    output logic              sent_o,
    output logic              drop_o,
    output logic              idle_o
);

    typedef struct packed {
        walk_state_e       st;
        logic [RING_W-1:0] idx;    // next slot to visit
        logic [RING_W-1:0] slot;   // slot being worked on
        logic [RING_W-1:0] cnt;    // slots consumed this kick
        logic [OFF_W-1:0]  off;    // running frame offset
        logic [31:0]       baddr;
        logic [15:0]       len;
        logic [15:0]       flags;
        logic [15:0]       pos;    // fragment byte or emit pointer
    } wk_t;

    wk_t d, q;

    logic [31:0]       slot_addr;
    logic [RING_W-1:0] idx_inc;
    logic [RING_W-1:0] idx_wrap;
    logic [RING_W-1:0] cnt_inc;
    logic [31:0]       frag_end;
    logic [OFF_W-1:0]  grown_off;

    // After a fragment is settled: last flag closes the frame, otherwise write back
    function automatic wk_t close_frag(input wk_t s, input logic [OFF_W-1:0] o);
        wk_t r;
        r     = s;
        r.pos = '0;
        r.off = o;
        r.st  = W_WBACK;
        if (s.flags[FLAG_LAST_BIT]) begin
            if (o != '0) r.st  = W_EMIT;
            else         r.off = '0;
        end
        return r;
    endfunction

    always_comb begin
        d           = q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        buf_we_o    = 1'b0;
        buf_waddr_o = '0;
        buf_wdata_o = '0;
        buf_raddr_o = '0;
        tx_valid_o  = 1'b0;
        tx_last_o   = 1'b0;
        sent_o      = 1'b0;
        drop_o      = 1'b0;

        slot_addr = ring_base_i + {{(32-RING_W-3){1'b0}}, q.slot, 3'b000};
        idx_inc   = RING_W'(q.idx + 1'b1);
        idx_wrap  = (idx_inc == ring_size_i) ? '0 : idx_inc;
        cnt_inc   = RING_W'(q.cnt + 1'b1);
        frag_end  = 32'(q.off) + 32'(mem_rdata_i[15:0]) + 32'd1;
        grown_off = OFF_W'(32'(q.off) + 32'(q.len) + 32'd1);

        case (q.st)
            W_IDLE: begin
                if (rewind_i) begin
                    d.idx = '0;
                    d.off = '0;
                end
                if (start_i && ring_size_i != '0) begin
                    d.cnt  = '0;
                    d.slot = d.idx;
                    d.st   = W_DADDR;
                end
            end

            W_DADDR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = slot_addr;
                if (mem_ready_i) begin
                    d.baddr = mem_rdata_i;
                    d.st    = W_DCTL;
                end
            end

            W_DCTL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = slot_addr + 32'd4;
                if (mem_ready_i) begin
                    d.len   = mem_rdata_i[15:0];
                    d.flags = mem_rdata_i[31:16];
                    d.pos   = '0;
                    if (!mem_rdata_i[16 + FLAG_VALID_BIT]) begin
                        d.st = W_IDLE;
                    end else begin
                        d.idx = idx_wrap;
                        if (frag_end > 32'(BUF_BYTES)) begin
                            drop_o = 1'b1;
                            d      = close_frag(d, q.off);
                        end else begin
                            d.st = W_FRAG;
                        end
                    end
                end
            end

            W_FRAG: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.baddr + 32'(q.pos);
                if (mem_ready_i) begin
                    buf_we_o    = 1'b1;
                    buf_waddr_o = BUF_AW'(32'(q.off) + 32'(q.pos));
                    buf_wdata_o = mem_rdata_i[7:0];
                    if (q.pos == q.len) d = close_frag(q, grown_off);
                    else                d.pos = q.pos + 16'd1;
                end
            end

            W_EMIT: begin
                tx_valid_o  = 1'b1;
                buf_raddr_o = BUF_AW'(q.pos);
                if (32'(q.pos) + 32'd1 == 32'(q.off)) begin
                    tx_last_o = 1'b1;
                    sent_o    = 1'b1;
                    d.off     = '0;
                    d.st      = W_WBACK;
                end else begin
                    d.pos = q.pos + 16'd1;
                end
            end

            W_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = slot_addr + 32'd4;
                mem_wdata_o = {q.flags & FLAG_KEEP_MASK, q.len};
                if (mem_ready_i) begin
                    d.cnt = cnt_inc;
                    if (q.flags[FLAG_LAST_BIT] || cnt_inc == ring_size_i) begin
                        d.st = W_IDLE;
                    end else begin
                        d.slot = q.idx;
                        d.st   = W_DADDR;
                    end
                end
            end

            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle_o = (q.st == W_IDLE);

endmodule

// File: rtl/tx_gather_engine.sv
module tx_gather_engine #(
    parameter int unsigned MTU    = 1500,
    parameter int unsigned RING_W = 8,
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              idle,
    output logic [STAT_W-1:0] irq_status,
    output logic              irq
);

    localparam int unsigned BUF_BYTES = MTU + 128;
    localparam int unsigned BUF_AW    = $clog2(BUF_BYTES);

    logic [31:0]       ring_base;
    logic [RING_W-1:0] ring_size;
    logic              start, rewind;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_waddr, buf_raddr;
    logic [7:0]        buf_wdata, buf_rdata;
    logic              sent, drop;

    tx_gather_cfg #(.RING_W(RING_W)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .busy_i      (!idle),
        .ring_base_o (ring_base),
        .ring_size_o (ring_size),
        .start_o     (start),
        .rewind_o    (rewind)
    );

    tx_gather_walker #(.RING_W(RING_W), .BUF_BYTES(BUF_BYTES)) i_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .rewind_i    (rewind),
        .ring_base_i (ring_base),
        .ring_size_i (ring_size),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_ready_i (mem_ready),
        .buf_we_o    (buf_we),
        .buf_waddr_o (buf_waddr),
        .buf_wdata_o (buf_wdata),
        .buf_raddr_o (buf_raddr),
        .tx_valid_o  (tx_valid),
        .tx_last_o   (tx_last),
        .sent_o      (sent),
        .drop_o      (drop),
        .idle_o      (idle)
    );

    tx_gather_fbuf #(.DEPTH(BUF_BYTES)) i_fbuf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (buf_waddr),
        .wdata_i (buf_wdata),
        .raddr_i (buf_raddr),
        .rdata_o (buf_rdata)
    );

    tx_gather_irq #(.STAT_W(STAT_W)) i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .sent_i      (sent),
        .drop_i      (drop),
        .status_o    (irq_status),
        .irq_o       (irq)
    );

    assign tx_data = tx_valid ? buf_rdata : 8'h00;

endmodule

// File: rtl/tx_gather_chk.sv
module tx_gather_chk #(
    parameter int unsigned STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              idle,
    input logic [STAT_W-1:0] irq_status,
    input logic              irq
);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    assert_wb_ctl_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[2:0] == 3'd4 && mem_wdata[31:17] == 15'd0);

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req && !tx_valid);

    assert_last_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_no_fetch_during_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

    assert_sent_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_last |=> irq_status[4]);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_status != '0);

endmodule

bind tx_gather_engine tx_gather_chk #(.STAT_W(STAT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .idle       (idle),
    .irq_status (irq_status),
    .irq        (irq)
);

// File: tb/test_tx_gather_engine.sv
`timescale 1ns/1ps
module test_tx_gather_engine;

    localparam int MTU    = 4;
    localparam int RING_W = 4;
    localparam int STAT_W = 8;
    localparam int RSIZE  = 4;
    localparam logic [31:0] BASE  = 32'h100;
    localparam logic [31:0] FRAGS = 32'h400;
    localparam logic [15:0] VLD   = 16'h8000;
    localparam logic [15:0] LST   = 16'h0001;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              reg_we;
    logic [2:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic              mem_req, mem_we, mem_ready;
    logic [31:0]       mem_addr, mem_wdata, mem_rdata;
    logic              tx_valid, tx_last, idle, irq;
    logic [7:0]        tx_data;
    logic [STAT_W-1:0] irq_status;

    tx_gather_engine #(.MTU(MTU), .RING_W(RING_W), .STAT_W(STAT_W)) i_tx_gather_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .idle(idle), .irq_status(irq_status), .irq(irq)
    );

    // ---------------- host memory model ----------------
    logic [7:0]  mem [0:2047];
    int          lat = 0;
    int          hs  = 0;
    logic [10:0] ma;
    assign ma        = mem_addr[10:0];
    assign mem_ready = mem_req && (lat == 0);
    assign mem_rdata = {mem[ma + 11'd3], mem[ma + 11'd2], mem[ma + 11'd1], mem[ma]};

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            hs  <= hs + 1;
            lat <= hs % 3;
            if (mem_we) begin
                mem[ma]         <= mem_wdata[7:0];
                mem[ma + 11'd1] <= mem_wdata[15:8];
                mem[ma + 11'd2] <= mem_wdata[23:16];
                mem[ma + 11'd3] <= mem_wdata[31:24];
            end
        end else if (mem_req && lat > 0) begin
            lat <= lat - 1;
        end
    end

    // ---------------- stream and port monitor ----------------
    logic [7:0]  rx_q [$];
    logic [7:0]  exp_q [$];
    int          frames = 0;
    int          r11_bad = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                rx_q.push_back(tx_data);
                if (tx_last) frames = frames + 1;
            end
            if (prev_wait && (!mem_req || mem_addr != prev_addr)) r11_bad = r11_bad + 1;
            prev_wait = mem_req && !mem_ready;
            prev_addr = mem_addr;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && !idle; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 13 + k * 7 + 1) & 8'hff);
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {mem[a[10:0] + 11'd3], mem[a[10:0] + 11'd2], mem[a[10:0] + 11'd1], mem[a[10:0]]};
    endfunction

    // place a descriptor and its fragment; expected bytes queued when asked
    task automatic put_desc(input int slot, input logic [15:0] len, input logic [15:0] flags,
                            input int seed, input bit expect_bytes);
        logic [31:0] da, ba;
        da = BASE + 32'(slot * 8);
        ba = FRAGS + 32'(slot * 128);
        for (int b = 0; b < 4; b++) begin
            mem[da[10:0] + 11'(b)]     <= ba[8*b +: 8];
            mem[da[10:0] + 11'(b + 4)] <= (b < 2) ? len[8*b +: 8] : flags[8*(b-2) +: 8];
        end
        for (int k = 0; k <= int'(len); k++) begin
            mem[ba[10:0] + 11'(k)] <= pat(seed, k);
            if (expect_bytes) exp_q.push_back(pat(seed, k));
        end
    endtask

    task automatic check_frame(input string req, input int exp_frames);
        int bad;
        chk({req, " frame count"}, 32'(frames), 32'(exp_frames));
        chk({req, " frame length"}, 32'(rx_q.size()), 32'(exp_q.size()));
        bad = -1;
        for (int i = 0; i < rx_q.size() && i < exp_q.size(); i++)
            if (bad < 0 && rx_q[i] != exp_q[i]) bad = i;
        if (bad >= 0) chk({req, " frame bytes"}, 32'(rx_q[bad]), 32'(exp_q[bad]));
        else          chk({req, " frame bytes"}, 32'd0, 32'd0);
        rx_q.delete();
        exp_q.delete();
    endtask

    function automatic logic [31:0] ctl_word(input int slot);
        return word_at(BASE + 32'(slot * 8) + 32'd4);
    endfunction

    int exp_idx = 0;
    int nframes = 0;

    initial begin
        rst_n = 1'b0;
        reg_we = 1'b0;
        reg_addr = '0;
        reg_wdata = '0;
        for (int i = 0; i < 2048; i++) mem[i] <= 8'h00;
        repeat (4) @(negedge clk);
        // R13: reset state
        chk("R13 idle", 32'(idle), 32'd1);
        chk("R13 irq", 32'(irq), 32'd0);
        chk("R13 status", 32'(irq_status), 32'd0);
        chk("R13 tx_valid", 32'(tx_valid), 32'd0);
        chk("R13 mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: low base bits ignored
        wr(3'd1, BASE | 32'h3);
        wr(3'd2, RSIZE);
        wr(3'd3, 32'h10);

        // Sweep: 1..3 fragments, varying lengths, junk status flags
        for (int p = 0; p < 12; p++) begin
            int nf;
            nf = p % 3 + 1;
            for (int k = 0; k < nf; k++) begin
                logic [15:0] fl;
                fl = VLD | ((k == nf - 1) ? LST : 16'h0) | ((p % 2 == 1) ? 16'h4A06 : 16'h0);
                put_desc((exp_idx + k) % RSIZE, 16'((p * 3 + k * 5) % 9), fl, p * 4 + k, 1'b1);
            end
            wr(3'd0, 32'h1);
            chk("R8 idle drops after kick", 32'(idle), 32'd0);
            wait_idle();
            chk("R8 idle back", 32'(idle), 32'd1);
            nframes++;
            check_frame("R2 R3 sweep", nframes);
            for (int k = 0; k < nf; k++)
                chk("R6 R1 write-back", ctl_word((exp_idx + k) % RSIZE),
                    {((k == nf - 1) ? LST : 16'h0), 16'((p * 3 + k * 5) % 9)});
            chk("R7 sent bit", 32'(irq_status), 32'h10);
            chk("R7 irq raised", 32'(irq), 32'd1);
            wr(3'd4, 32'h10);
            chk("R7 cleared", 32'(irq), 32'd0);
            exp_idx = (exp_idx + nf) % RSIZE;
        end

        // R4: walk halts on invalid slot, offset carried to next kick
        put_desc(exp_idx, 16'd3, VLD, 90, 1'b1);
        put_desc((exp_idx + 1) % RSIZE, 16'd2, 16'h0, 91, 1'b0);
        wr(3'd0, 32'h1);
        wait_idle();
        chk("R4 no frame yet", 32'(frames), 32'(nframes));
        chk("R4 consumed slot", ctl_word(exp_idx), {16'h0, 16'd3});
        chk("R4 invalid slot untouched", ctl_word((exp_idx + 1) % RSIZE), {16'h0, 16'd2});
        put_desc((exp_idx + 1) % RSIZE, 16'd2, VLD | LST, 92, 1'b1);
        wr(3'd0, 32'h1);
        wait_idle();
        nframes++;
        check_frame("R4 R2 resumed frame", nframes);
        exp_idx = (exp_idx + 2) % RSIZE;
        wr(3'd4, 32'hff);

        // R5: full ring without last flag, then wrap
        for (int k = 0; k < RSIZE; k++) put_desc((exp_idx + k) % RSIZE, 16'd1, VLD, 100 + k, 1'b1);
        wr(3'd0, 32'h1);
        wait_idle();
        chk("R5 no frame", 32'(frames), 32'(nframes));
        for (int k = 0; k < RSIZE; k++)
            chk("R5 each slot consumed once", ctl_word(k), {16'h0, 16'd1});
        put_desc(exp_idx, 16'd0, VLD | LST, 110, 1'b1);
        wr(3'd0, 32'h1);
        wait_idle();
        nframes++;
        check_frame("R5 wrapped frame", nframes);
        exp_idx = (exp_idx + 1) % RSIZE;
        wr(3'd4, 32'hff);

        // R5: ring size zero makes kick a no-op
        put_desc(exp_idx, 16'd0, VLD | LST, 115, 1'b0);
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h1);
        chk("R5 size zero stays idle", 32'(idle), 32'd1);
        repeat (10) @(negedge clk);
        chk("R5 size zero untouched", ctl_word(exp_idx), {VLD | LST, 16'd0});
        wr(3'd2, RSIZE);

        // R9: partial gather then rewind together with kick
        put_desc(exp_idx, 16'd5, VLD, 120, 1'b0);
        put_desc((exp_idx + 1) % RSIZE, 16'd0, 16'h0, 121, 1'b0);
        wr(3'd0, 32'h1);
        wait_idle();
        put_desc(0, 16'd4, VLD | LST, 122, 1'b1);
        wr(3'd0, 32'h3);
        wait_idle();
        nframes++;
        check_frame("R9 rewind drops partial", nframes);
        chk("R9 slot0 consumed", ctl_word(0), {LST, 16'd4});
        exp_idx = 1;
        wr(3'd4, 32'hff);

        // R10: overflow of the 132-byte buffer
        put_desc(1, 16'd99, VLD, 130, 1'b1);
        put_desc(2, 16'd39, VLD | LST | 16'h0100, 131, 1'b0);
        wr(3'd0, 32'h1);
        wait_idle();
        nframes++;
        check_frame("R10 kept bytes", nframes);
        chk("R10 drop and sent bits", 32'(irq_status), 32'h30);
        chk("R10 dropped slot written back", ctl_word(2), {LST, 16'd39});
        // R7: clearing one bit keeps the other, mask gating
        wr(3'd4, 32'h10);
        chk("R7 other bit kept", 32'(irq_status), 32'h20);
        chk("R7 masked off", 32'(irq), 32'd0);
        wr(3'd3, 32'h20);
        chk("R7 mask enables", 32'(irq), 32'd1);
        wr(3'd4, 32'h20);
        chk("R7 all clear", 32'(irq), 32'd0);
        exp_idx = 3;

        // R12: config writes during a walk are ignored
        put_desc(3, 16'd60, VLD | LST, 140, 1'b1);
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h180);
        wr(3'd2, 32'd1);
        wr(3'd0, 32'h2);
        wait_idle();
        nframes++;
        check_frame("R12 long frame", nframes);
        put_desc(0, 16'd1, VLD | LST, 150, 1'b1);
        wr(3'd0, 32'h1);
        wait_idle();
        nframes++;
        check_frame("R12 base and index unchanged", nframes);
        chk("R12 slot0 consumed", ctl_word(0), {LST, 16'd1});

        chk("R11 request held until ready", 32'(r11_bad), 32'd0);
        summary();
    end

endmodule